// File: doc/BRIEF.md
# Phase Voltage Source Router

The router sits between the voltage sampling front end and three per-phase computation paths. Each clock cycle with the sample strobe high carries one signed sample for each of the three phase voltages. For each of the three destination paths, the router picks one of those three inputs and passes it on. This lets a path pair one phase's voltage with another phase's current further down the chain. The routed samples leave through a single output register stage, with a strobe that follows the input strobe exactly one cycle later.

The routing is set by a 32-bit configuration word that is written through a simple write port and can be read back whole. Each destination owns a 2-bit selector field in that word. The code is read as a rotation relative to the destination's own phase: 00 picks its own phase, 01 picks the next phase in the order A, B, C, A, and 10 picks the phase after that. The code 11 is reserved and acts exactly like 00. After reset every selector is 00, so each phase feeds its own path.

Top module: `pvr_router`

## Requirements
- R1: After a synchronous reset, cfg_rd_data is 0, out_valid_o is 0 and every routed output is 0. Each path then routes its own phase.
- R2: The path A source comes from configuration bits [9:8]: 00 selects phase A, 01 selects phase B, 10 selects phase C.
- R3: The path B source comes from configuration bits [11:10]: 00 selects phase B, 01 selects phase C, 10 selects phase A.
- R4: The path C source comes from configuration bits [13:12]: 00 selects phase C, 01 selects phase A, 10 selects phase B.
- R5: A selector field holding 11 routes its path exactly as 00 does.
- R6: Each routed output and out_valid_o appear exactly one clock after the input sample cycle, with the same latency on all three paths.
- R7: While smp_valid_i is low, the routed outputs keep their last values and out_valid_o is low one cycle later, whatever the sample inputs do.
- R8: A configuration write takes effect for samples from the next cycle on. A sample presented in the same cycle as the write is routed by the previous setting.
- R9: cfg_rd_data returns all 32 written bits one cycle after the write. Bits outside [13:8] have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration word to write |
| cfg_rd_data | output | 32 | Current configuration word |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_a_i | input | 24 | Phase A voltage sample, signed |
| smp_b_i | input | 24 | Phase B voltage sample, signed |
| smp_c_i | input | 24 | Phase C voltage sample, signed |
| out_valid_o | output | 1 | Routed sample strobe |
| out_a_o | output | 24 | Sample for path A, signed |
| out_b_o | output | 24 | Sample for path B, signed |
| out_c_o | output | 24 | Sample for path C, signed |

## Verification
Every sample gives the three phases different random signed values, so a route to the wrong phase always shows up as a mismatch. Each path's field is stepped through all four codes while the other fields hold non-default values; this separates a wrong rotation direction, a swapped field position and a mishandled reserved code. Idle gaps with moving inputs separate a held register from one that keeps loading. Writes that coincide with a sample, and words with every unrelated bit set, separate a correct update boundary and field decode from a premature switch or a decode that reads the wrong bits.

// File: rtl/pvr_pkg.sv
`timescale 1ns/1ps
package pvr_pkg;

    localparam int NUM_PH   = 3;
    localparam int SEL_W    = 2;
    localparam int CFG_W    = 32;
    // Selector field of destination k sits at [SEL_BASE+SEL_W*k +: SEL_W]
    localparam int SEL_BASE = 8;
    localparam int SEL_TOP  = SEL_BASE + SEL_W * NUM_PH - 1;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_OWN  = 2'b00,
        SEL_NEXT = 2'b01,
        SEL_SKIP = 2'b10,
        SEL_RSVD = 2'b11
    } sel_e;

    // Source phase = destination rotated forward by the code (mod 3).
    // The reserved code has no rotation.
    function automatic phase_e src_phase(phase_e dst, sel_e code);
        logic [2:0] step;
        logic [2:0] sum;
        case (code)
            SEL_NEXT: step = 3'd1;
            SEL_SKIP: step = 3'd2;
            default:  step = 3'd0;
        endcase
        sum = {1'b0, dst} + step;
        if (sum >= 3'd3) sum = sum - 3'd3;
        return phase_e'(sum[1:0]);
    endfunction

endpackage

// File: rtl/pvr_cfg_reg.sv
`timescale 1ns/1ps
module pvr_cfg_reg
    import pvr_pkg::*;
#(
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] rd_data,
    output sel_e          sel [NUM_PH]
);

    logic [CW-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= wr_data;
    end

    assign rd_data = cfg_q;

    for (genvar k = 0; k < NUM_PH; k++) begin : g_field
        assign sel[k] = sel_e'(cfg_q[SEL_BASE + SEL_W*k +: SEL_W]);
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> rd_data == '0)
        else $error("config not cleared by reset");

    p_readback_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == $past(wr_data))
        else $error("config readback differs from written word");

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data))
        else $error("config changed without a write");

endmodule

// File: rtl/pvr_src_mux.sv
`timescale 1ns/1ps
module pvr_src_mux
    import pvr_pkg::*;
#(
    parameter int     SW  = 24,
    parameter phase_e DST = PH_A
) (
    input  logic signed [SW-1:0] smp [NUM_PH],
    input  sel_e                 sel,
    output logic signed [SW-1:0] routed
);

    phase_e src;

    always_comb begin
        src = src_phase(DST, sel);
        case (src)
            PH_B:    routed = smp[1];
            PH_C:    routed = smp[2];
            default: routed = smp[0];
        endcase
    end

endmodule

// File: rtl/pvr_out_stage.sv
`timescale 1ns/1ps
module pvr_out_stage
    import pvr_pkg::*;
#(
    parameter int SW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_i,
    input  logic signed [SW-1:0] d [NUM_PH],
    output logic                 valid_o,
    output logic signed [SW-1:0] q [NUM_PH]
);

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= valid_i;
    end

    for (genvar k = 0; k < NUM_PH; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)          q[k] <= '0;
            else if (valid_i) q[k] <= d[k];
        end

        p_capture_r6: assert property (@(posedge clk) disable iff (rst)
            valid_i |=> q[k] == $past(d[k]))
            else $error("lane %0d did not capture routed sample", k);

        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !valid_i |=> $stable(q[k]))
            else $error("lane %0d changed without strobe", k);

        p_lane_reset_r1: assert property (@(posedge clk) rst |=> q[k] == '0)
            else $error("lane %0d not cleared by reset", k);
    end

    p_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o)
        else $error("output strobe missing");

    p_strobe_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o)
        else $error("output strobe without input sample");

endmodule

// File: rtl/pvr_router.sv
`timescale 1ns/1ps
module pvr_router
    import pvr_pkg::*;
#(
    parameter int SW = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic [CFG_W-1:0]     cfg_wr_data,
    output logic [CFG_W-1:0]     cfg_rd_data,
    input  logic                 smp_valid_i,
    input  logic signed [SW-1:0] smp_a_i,
    input  logic signed [SW-1:0] smp_b_i,
    input  logic signed [SW-1:0] smp_c_i,
    output logic                 out_valid_o,
    output logic signed [SW-1:0] out_a_o,
    output logic signed [SW-1:0] out_b_o,
    output logic signed [SW-1:0] out_c_o
);

    sel_e                 sel    [NUM_PH];
    logic signed [SW-1:0] smp    [NUM_PH];
    logic signed [SW-1:0] routed [NUM_PH];
    logic signed [SW-1:0] q      [NUM_PH];

    assign smp[0] = smp_a_i;
    assign smp[1] = smp_b_i;
    assign smp[2] = smp_c_i;

    pvr_cfg_reg #(.CW(CFG_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .sel     (sel)
    );

    for (genvar k = 0; k < NUM_PH; k++) begin : g_path
        pvr_src_mux #(.SW(SW), .DST(phase_e'(k))) u_mux (
            .smp    (smp),
            .sel    (sel[k]),
            .routed (routed[k])
        );
    end

    pvr_out_stage #(.SW(SW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .valid_i (smp_valid_i),
        .d       (routed),
        .valid_o (out_valid_o),
        .q       (q)
    );

    assign out_a_o = q[0];
    assign out_b_o = q[1];
    assign out_c_o = q[2];

    // Port-level routing checks against the live selector fields
    p_route_a_next_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i && sel[0] == SEL_NEXT |=> out_a_o == $past(smp_b_i))
        else $error("path A code 01 not routed from phase B");

    p_route_a_skip_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i && sel[0] == SEL_SKIP |=> out_a_o == $past(smp_c_i))
        else $error("path A code 10 not routed from phase C");

    p_route_b_next_r3: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i && sel[1] == SEL_NEXT |=> out_b_o == $past(smp_c_i))
        else $error("path B code 01 not routed from phase C");

    p_route_b_skip_r3: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i && sel[1] == SEL_SKIP |=> out_b_o == $past(smp_a_i))
        else $error("path B code 10 not routed from phase A");

    p_route_c_next_r4: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i && sel[2] == SEL_NEXT |=> out_c_o == $past(smp_a_i))
        else $error("path C code 01 not routed from phase A");

    p_route_c_skip_r4: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i && sel[2] == SEL_SKIP |=> out_c_o == $past(smp_b_i))
        else $error("path C code 10 not routed from phase B");

    p_rsvd_own_r5: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i && sel[0] == SEL_RSVD && sel[1] == SEL_RSVD && sel[2] == SEL_RSVD
        |=> out_a_o == $past(smp_a_i) && out_b_o == $past(smp_b_i) && out_c_o == $past(smp_c_i))
        else $error("reserved code did not route own phase");

    p_write_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en && smp_valid_i && sel[0] == SEL_OWN |=> out_a_o == $past(smp_a_i))
        else $error("write changed routing of coincident sample");

    p_out_reset_r1: assert property (@(posedge clk) rst |=> !out_valid_o)
        else $error("output strobe set after reset");

endmodule

// File: tb/test_pvr_router.sv
`timescale 1ns/1ps
module test_pvr_router;

    localparam int SW = 24;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                 rst = 1'b1;
    logic                 cfg_wr_en = 1'b0;
    logic [31:0]          cfg_wr_data = '0;
    logic [31:0]          cfg_rd_data;
    logic                 smp_valid_i = 1'b0;
    logic signed [SW-1:0] smp_a_i = '0, smp_b_i = '0, smp_c_i = '0;
    logic                 out_valid_o;
    logic signed [SW-1:0] out_a_o, out_b_o, out_c_o;

    pvr_router #(.SW(SW)) i_pvr_router (
        .clk, .rst, .cfg_wr_en, .cfg_wr_data, .cfg_rd_data,
        .smp_valid_i, .smp_a_i, .smp_b_i, .smp_c_i,
        .out_valid_o, .out_a_o, .out_b_o, .out_c_o
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // ---------------- reference model ----------------
    logic [31:0] m_cfg = '0;
    logic        m_valid = 1'b0;
    int          m_out [3] = '{0, 0, 0};

    // Source index per destination: A=0, B=1, C=2; code 3 behaves as 0.
    function automatic int pick(int dst, int code);
        int c;
        c = (code == 3) ? 0 : code;
        case (dst)
            0:       return (c == 0) ? 0 : (c == 1) ? 1 : 2;
            1:       return (c == 0) ? 1 : (c == 1) ? 2 : 0;
            default: return (c == 0) ? 2 : (c == 1) ? 0 : 1;
        endcase
    endfunction

    always @(posedge clk) begin
        int inp [3];
        inp[0] = int'(smp_a_i);
        inp[1] = int'(smp_b_i);
        inp[2] = int'(smp_c_i);
        if (rst) begin
            m_cfg   = '0;
            m_valid = 1'b0;
            m_out   = '{0, 0, 0};
        end else begin
            m_valid = smp_valid_i;
            if (smp_valid_i)
                for (int d = 0; d < 3; d++)
                    m_out[d] = inp[pick(d, int'(m_cfg[8 + 2*d +: 2]))];
            if (cfg_wr_en) m_cfg = cfg_wr_data;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done && !rst) begin
            check(cur_req, "out_valid_o", longint'(out_valid_o), longint'(m_valid));
            check(cur_req, "out_a_o", longint'(out_a_o), longint'(m_out[0]));
            check(cur_req, "out_b_o", longint'(out_b_o), longint'(m_out[1]));
            check(cur_req, "out_c_o", longint'(out_c_o), longint'(m_out[2]));
            check(cur_req, "cfg_rd_data", longint'(cfg_rd_data), longint'(m_cfg));
        end
    end

    // ---------------- stimulus ----------------
    task automatic randomize_inputs();
        smp_a_i = SW'($urandom);
        smp_b_i = SW'($urandom);
        smp_c_i = SW'($urandom);
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_wr_en   = 1'b0;
            smp_valid_i = 1'b1;
            randomize_inputs();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_wr_en   = 1'b0;
            smp_valid_i = 1'b0;
            randomize_inputs();
        end
    endtask

    task automatic write_cfg(input logic [31:0] v, input bit with_sample);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        smp_valid_i = with_sample;
        randomize_inputs();
    endtask

    function automatic logic [31:0] fields(input int a, input int b, input int c);
        return (32'(a) << 8) | (32'(b) << 10) | (32'(c) << 12);
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state seen at the ports while reset is still held
        check("R1", "reset out_valid_o", longint'(out_valid_o), 0);
        check("R1", "reset out_a_o", longint'(out_a_o), 0);
        check("R1", "reset cfg_rd_data", longint'(cfg_rd_data), 0);
        rst = 1'b0;
        cur_req = "R1";
        send(4);
        idle(2);

        // R2: path A codes, other fields non-default
        cur_req = "R2";
        for (int code = 0; code < 3; code++) begin
            write_cfg(fields(code, 1, 2), 1'b0);
            send(3); idle(1);
        end
        // R3: path B codes
        cur_req = "R3";
        for (int code = 0; code < 3; code++) begin
            write_cfg(fields(2, code, 1), 1'b0);
            send(3); idle(1);
        end
        // R4: path C codes
        cur_req = "R4";
        for (int code = 0; code < 3; code++) begin
            write_cfg(fields(1, 2, code), 1'b0);
            send(3); idle(1);
        end
        // R5: reserved code on each path, alone and all together
        cur_req = "R5";
        write_cfg(fields(3, 1, 1), 1'b0); send(3);
        write_cfg(fields(2, 3, 2), 1'b0); send(3);
        write_cfg(fields(1, 1, 3), 1'b0); send(3);
        write_cfg(fields(3, 3, 3), 1'b0); send(3);
        idle(1);
        // R6: back-to-back samples, latency and strobe
        cur_req = "R6";
        write_cfg(fields(1, 2, 1), 1'b0);
        send(8); idle(1); send(1); idle(1); send(2);
        // R7: long gap with moving inputs
        cur_req = "R7";
        idle(6); send(1); idle(5);
        // R8: writes coincident with samples
        cur_req = "R8";
        write_cfg(fields(0, 0, 0), 1'b1); send(2);
        write_cfg(fields(2, 1, 2), 1'b1); send(2);
        write_cfg(fields(1, 2, 0), 1'b1); write_cfg(fields(0, 1, 1), 1'b1); send(2);
        idle(2);
        // R9: unrelated bits fully set, readback of whole word
        cur_req = "R9";
        write_cfg(32'hFFFF_C0FF, 1'b0); send(3);
        write_cfg(32'hA5A5_C05A | fields(1, 2, 1), 1'b0); send(3);
        write_cfg(32'h0000_0000, 1'b0); send(2); idle(2);
        // R1: reset mid-run clears everything again
        cur_req = "R1";
        write_cfg(fields(2, 2, 2), 1'b0); send(2);
        @(negedge clk); rst = 1'b1; smp_valid_i = 1'b1; cfg_wr_en = 1'b0;
        @(negedge clk); rst = 1'b0; smp_valid_i = 1'b0;
        check("R1", "post-reset cfg_rd_data", longint'(cfg_rd_data), 0);
        check("R1", "post-reset out_b_o", longint'(out_b_o), 0);
        send(3); idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule